// File: doc/BRIEF.md
# Register-Memory Transfer Sequencer

This block carries out the multi-cycle memory and index-pointer work of a small 8-bit register machine with sixteen data registers and a 12-bit index pointer. It accepts one 16-bit instruction word per start pulse. It then does one of four things:

- writes the decimal digits of a register to memory;
- copies a run of registers out to memory;
- fills a run of registers from memory;
- updates the index pointer.

The index pointer can be loaded with a constant, aimed at a character glyph, or advanced by a register value. Display and arithmetic operations belong to other blocks.

The surrounding core owns the register file. The block reads it through a combinational read port and writes it through a single write port. It drives one byte-wide synchronous memory port whose read data arrives one cycle after the address. `busy` is high from the cycle after a start is accepted until the end of the `done` cycle. Starts that arrive while `busy` is high are dropped.

Top module: `regmem_xfer_seq`

## Requirements
- R1: After reset the index pointer reads 0, `busy` and `done` are low, and no memory or register-file strobe is active until a start is accepted.
- R2: Instruction 0xANNN (bits 15:12 equal 0xA) sets the index to NNN, makes no memory or register access, and pulses `done` in the cycle after the start.
- R3: Instruction 0xFX33 writes three bytes of Vx in decimal: hundreds at index, tens at index+1 and units at index+2, each modulo 4096. The index is unchanged afterwards.
- R4: The decimal-digit operation raises `done` exactly 12 rising edges after the edge that accepts it, counting that edge as the first.
- R5: Instruction 0xFX55 writes V0..Vx, in ascending register order, to addresses index, index+1, and so on. The index ends at its old value plus X+1.
- R6: Instruction 0xFX65 reads addresses index..index+X. The byte at index+k is written to Vk in the cycle after its address is presented. The index ends at its old value plus X+1.
- R7: Instruction 0xFX29 sets the index to 0x050 + 5*(Vx & 0xF). `glyph_warn` is high together with `done` exactly when Vx exceeds 0x0F.
- R8: Instruction 0xFX1E sets the index to (index + Vx) modulo 4096 and performs no register-file write.
- R9: Any other instruction word pulses `done` in the cycle after the start, with no memory or register access, and leaves the index unchanged.
- R10: A start asserted while `busy` is high is ignored: it neither changes the index nor lengthens the running operation.
- R11: `done` is a one-cycle pulse, and `busy` is low in the cycle after `done`.
- R12: Index increments and address offsets wrap modulo 4096. A block store starting at 0xFFE with X=3 writes to 0xFFE, 0xFFF, 0x000 and 0x001 and leaves the index at 0x002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the operation in `instr`; sampled only while idle |
| instr | input | 16 | Instruction word: bits 15:12 class, 11:8 register X, 7:0 sub-operation or 11:0 constant |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| glyph_warn | output | 1 | Glyph source register was above 0x0F (valid with `done`) |
| index_o | output | 12 | Current index pointer |
| rf_rd_addr | output | 4 | Register-file read address |
| rf_rd_data | input | 8 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_addr | output | 4 | Register-file write address |
| rf_wr_data | output | 8 | Register-file write data |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 12 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |

## Verification
A corrupted digit shift register shows up at the memory port as a wrong digit byte within the three write cycles that close the twelve-cycle digit sequence. A slipped loop counter shows up at once as a missing or extra write strobe, and as an index that ends one step off when `done` rises. A stale load pipeline register writes the wrong register in the cycle right after a read. Each such fault therefore reaches the ports at the latest by the `done` pulse of the same instruction.

// File: rtl/rmx_pkg.sv
package rmx_pkg;

  // controller states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DAB,
    ST_DIG,
    ST_SAVE,
    ST_LOAD,
    ST_DRAIN,
    ST_DONE
  } seq_st_t;

  // index register update selector
  typedef enum logic [2:0] {
    IX_HOLD,
    IX_NNN,
    IX_ADD,
    IX_GLYPH,
    IX_INC
  } ix_op_t;

  // instruction class nibble (bits 15:12)
  localparam logic [3:0] OPC_IDX  = 4'hA;
  localparam logic [3:0] OPC_MISC = 4'hF;

  // sub-operation byte (bits 7:0) of the misc class
  localparam logic [7:0] SUB_DIGITS = 8'h33;
  localparam logic [7:0] SUB_STORE  = 8'h55;
  localparam logic [7:0] SUB_LOAD   = 8'h65;
  localparam logic [7:0] SUB_GLYPH  = 8'h29;
  localparam logic [7:0] SUB_ADDIX  = 8'h1E;

endpackage

// File: rtl/rmx_digits.sv
// Sequential binary to decimal converter (shift and add-3), one bit per step.
module rmx_digits #(
  parameter int BW     = 8,
  parameter int DIGITS = 3,
  localparam int DW    = 4 * DIGITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [BW-1:0] value,
  output logic [DW-1:0] bcd
);

  function automatic logic [3:0] dd_fix(input logic [3:0] nib);
    return (nib >= 4'd5) ? nib + 4'd3 : nib;
  endfunction

  logic [BW-1:0] bin_q;
  logic [DW-1:0] bcd_q;
  logic [DW-1:0] adj;

  for (genvar g = 0; g < DIGITS; g++) begin : g_fix
    assign adj[4*g +: 4] = dd_fix(bcd_q[4*g +: 4]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q <= '0;
      bcd_q <= '0;
    end else if (load) begin
      bin_q <= value;
      bcd_q <= '0;
    end else if (step) begin
      bcd_q <= (adj << 1) | {{(DW-1){1'b0}}, bin_q[BW-1]};
      bin_q <= bin_q << 1;
    end
  end

  assign bcd = bcd_q;

endmodule

// File: rtl/rmx_index.sv
// Index pointer with its update arithmetic.
module rmx_index
  import rmx_pkg::*;
#(
  parameter int AW           = 12,
  parameter int BW           = 8,
  parameter int FONT_BASE    = 'h050,
  parameter int GLYPH_STRIDE = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ix_op_t        op,
  input  logic [AW-1:0] nnn,
  input  logic [BW-1:0] vx,
  output logic [AW-1:0] idx
);

  function automatic logic [AW-1:0] glyph_addr(input logic [3:0] nib);
    return AW'(FONT_BASE) + AW'(GLYPH_STRIDE) * AW'(nib);
  endfunction

  function automatic logic [AW-1:0] add_wrap(input logic [AW-1:0] a,
                                             input logic [AW-1:0] b);
    return a + b;
  endfunction

  logic [AW-1:0] idx_q, idx_d;

  always_comb begin
    unique case (op)
      IX_NNN:   idx_d = nnn;
      IX_ADD:   idx_d = add_wrap(idx_q, AW'(vx));
      IX_GLYPH: idx_d = glyph_addr(vx[3:0]);
      IX_INC:   idx_d = add_wrap(idx_q, AW'(1));
      default:  idx_d = idx_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx = idx_q;

endmodule

// File: rtl/rmx_ctrl.sv
// Sequencer: decodes the instruction and steps through the operation.
module rmx_ctrl
  import rmx_pkg::*;
#(
  parameter int BW     = 8,
  parameter int DIGITS = 3,
  parameter int RW     = 4,
  parameter int CW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   instr,
  input  logic          vx_hi_nz,
  output seq_st_t       st,
  output logic          busy,
  output logic          done,
  output logic          warn,
  output ix_op_t        ix_op,
  output logic [CW-1:0] cnt,
  output logic          dab_load,
  output logic          dab_step,
  output logic          mem_en,
  output logic          mem_we,
  output logic          dig_sel,
  output logic [RW-1:0] rd_sel,
  output logic          rf_we,
  output logic [RW-1:0] rf_wa
);

  seq_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] x_q;
  logic          warn_q;
  logic          pend_q;
  logic [RW-1:0] wa_q;
  logic          accept;
  logic          is_glyph;

  assign accept   = (st_q == ST_IDLE) && start;
  assign is_glyph = (instr[15:12] == OPC_MISC) && (instr[7:0] == SUB_GLYPH);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    ix_op    = IX_HOLD;
    dab_load = 1'b0;
    dab_step = 1'b0;
    mem_en   = 1'b0;
    mem_we   = 1'b0;
    dig_sel  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          cnt_d = '0;
          st_d  = ST_DONE;
          if (instr[15:12] == OPC_IDX) begin
            ix_op = IX_NNN;
          end else if (instr[15:12] == OPC_MISC) begin
            case (instr[7:0])
              SUB_DIGITS: begin dab_load = 1'b1; st_d = ST_DAB; end
              SUB_STORE:  st_d  = ST_SAVE;
              SUB_LOAD:   st_d  = ST_LOAD;
              SUB_GLYPH:  ix_op = IX_GLYPH;
              SUB_ADDIX:  ix_op = IX_ADD;
              default:    ;
            endcase
          end
        end
      end
      ST_DAB: begin
        dab_step = 1'b1;
        if (cnt_q == CW'(BW - 1)) begin
          cnt_d = '0;
          st_d  = ST_DIG;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DIG: begin
        mem_en  = 1'b1;
        mem_we  = 1'b1;
        dig_sel = 1'b1;
        if (cnt_q == CW'(DIGITS - 1)) st_d = ST_DONE;
        else                          cnt_d = cnt_q + 1'b1;
      end
      ST_SAVE: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
        ix_op  = IX_INC;
        if (cnt_q == CW'(x_q)) st_d = ST_DONE;
        else                   cnt_d = cnt_q + 1'b1;
      end
      ST_LOAD: begin
        mem_en = 1'b1;
        ix_op  = IX_INC;
        if (cnt_q == CW'(x_q)) st_d = ST_DRAIN;
        else                   cnt_d = cnt_q + 1'b1;
      end
      ST_DRAIN: st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      x_q    <= '0;
      warn_q <= 1'b0;
      pend_q <= 1'b0;
      wa_q   <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      pend_q <= (st_q == ST_LOAD);
      wa_q   <= cnt_q[RW-1:0];
      if (accept) begin
        x_q    <= RW'(instr[11:8]);
        warn_q <= is_glyph && vx_hi_nz;
      end
    end
  end

  always_comb begin
    if (st_q == ST_IDLE)      rd_sel = RW'(instr[11:8]);
    else if (st_q == ST_SAVE) rd_sel = cnt_q[RW-1:0];
    else                      rd_sel = x_q;
  end

  assign st    = st_q;
  assign cnt   = cnt_q;
  assign busy  = (st_q != ST_IDLE);
  assign done  = (st_q == ST_DONE);
  assign warn  = warn_q && (st_q == ST_DONE);
  assign rf_we = pend_q;
  assign rf_wa = wa_q;

endmodule

// File: rtl/regmem_xfer_seq.sv
// Register-memory transfer sequencer top level.
module regmem_xfer_seq
  import rmx_pkg::*;
#(
  parameter int AW           = 12,
  parameter int BW           = 8,
  parameter int REGS         = 16,
  parameter int DIGITS       = 3,
  parameter int FONT_BASE    = 'h050,
  parameter int GLYPH_STRIDE = 5,
  localparam int RW          = $clog2(REGS),
  localparam int CW          = (RW > $clog2(BW)) ? RW : $clog2(BW),
  localparam int DW          = 4 * DIGITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   instr,
  output logic          busy,
  output logic          done,
  output logic          glyph_warn,
  output logic [AW-1:0] index_o,
  output logic [RW-1:0] rf_rd_addr,
  input  logic [BW-1:0] rf_rd_data,
  output logic          rf_we,
  output logic [RW-1:0] rf_wr_addr,
  output logic [BW-1:0] rf_wr_data,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] mem_wdata,
  input  logic [BW-1:0] mem_rdata
);

  seq_st_t       st;
  ix_op_t        ix_op;
  logic [CW-1:0] cnt;
  logic          dab_load, dab_step, dig_sel;
  logic [DW-1:0] bcd;
  logic [AW-1:0] index_q;
  logic [3:0]    dig_nib;

  // named events for the checker
  logic dig_wr_ev, ld_rd_ev, nnn_ev;

  rmx_ctrl #(
    .BW(BW), .DIGITS(DIGITS), .RW(RW), .CW(CW)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .instr    (instr),
    .vx_hi_nz (|rf_rd_data[BW-1:4]),
    .st       (st),
    .busy     (busy),
    .done     (done),
    .warn     (glyph_warn),
    .ix_op    (ix_op),
    .cnt      (cnt),
    .dab_load (dab_load),
    .dab_step (dab_step),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .dig_sel  (dig_sel),
    .rd_sel   (rf_rd_addr),
    .rf_we    (rf_we),
    .rf_wa    (rf_wr_addr)
  );

  rmx_digits #(
    .BW(BW), .DIGITS(DIGITS)
  ) u_digits (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (dab_load),
    .step  (dab_step),
    .value (rf_rd_data),
    .bcd   (bcd)
  );

  rmx_index #(
    .AW(AW), .BW(BW), .FONT_BASE(FONT_BASE), .GLYPH_STRIDE(GLYPH_STRIDE)
  ) u_index (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (ix_op),
    .nnn   (instr[AW-1:0]),
    .vx    (rf_rd_data),
    .idx   (index_q)
  );

  // most significant digit first
  always_comb begin
    dig_nib = '0;
    for (int k = 0; k < DIGITS; k++)
      if (cnt == CW'(k)) dig_nib = bcd[4*(DIGITS-1-k) +: 4];
  end

  assign mem_addr   = index_q + (dig_sel ? AW'(cnt) : AW'(0));
  assign mem_wdata  = dig_sel ? BW'(dig_nib) : rf_rd_data;
  assign rf_wr_data = mem_rdata;
  assign index_o    = index_q;

  assign dig_wr_ev = dig_sel && mem_we;
  assign ld_rd_ev  = (st == ST_LOAD);
  assign nnn_ev    = (ix_op == IX_NNN);

endmodule

// File: rtl/rmx_checker.sv
// Protocol checker, bound into the top level.
module rmx_checker #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          warn,
  input logic          mem_en,
  input logic          rf_we,
  input logic [AW-1:0] idx,
  input logic          dig_wr,
  input logic          ld_rd,
  input logic          nnn_ev
);

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_en && !rf_we));

  p_nnn_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    nnn_ev |=> !mem_en);

  p_digit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dig_wr |=> $stable(idx));

  p_load_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(ld_rd));

  p_warn_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    warn |-> done);

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

endmodule

bind regmem_xfer_seq rmx_checker #(.AW(AW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .done   (done),
  .warn   (glyph_warn),
  .mem_en (mem_en),
  .rf_we  (rf_we),
  .idx    (index_q),
  .dig_wr (dig_wr_ev),
  .ld_rd  (ld_rd_ev),
  .nnn_ev (nnn_ev)
);

// File: tb/regmem_xfer_seq_bench.sv
module regmem_xfer_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic        busy, done, glyph_warn;
  logic [11:0] index_o;
  logic [3:0]  rf_rd_addr, rf_wr_addr;
  logic [7:0]  rf_rd_data, rf_wr_data;
  logic        rf_we, mem_en, mem_we;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  logic [7:0]  mem [0:4095];
  logic [7:0]  rf  [0:15];

  int          n_tests = 0;
  int          n_fail  = 0;
  string       cur_req = "R1";
  logic [11:0] exp_idx = '0;
  logic [19:0] exp_mem [$];
  logic [11:0] exp_rf  [$];

  always #5 clk = ~clk;

  regmem_xfer_seq u_regmem_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .busy(busy), .done(done), .glyph_warn(glyph_warn), .index_o(index_o),
    .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data), .rf_we(rf_we),
    .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  assign rf_rd_data = rf[rf_rd_addr];

  // memory with one-cycle read latency, and the register file
  always @(posedge clk) begin
    if (mem_en && mem_we)  mem[mem_addr] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= mem[mem_addr];
    if (rf_we)             rf[rf_wr_addr] <= rf_wr_data;
  end

  task automatic check(input string req, input bit ok, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as strobes appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_en && mem_we) begin
        if (exp_mem.size() == 0) begin
          check(cur_req, 1'b0, "unexpected memory write", {mem_addr, mem_wdata}, 0);
        end else begin
          logic [19:0] e;
          e = exp_mem.pop_front();
          check(cur_req, {mem_addr, mem_wdata} == e, "memory write {addr,data}",
                {mem_addr, mem_wdata}, e);
        end
      end
      if (rf_we) begin
        if (exp_rf.size() == 0) begin
          check(cur_req, 1'b0, "unexpected register write", {rf_wr_addr, rf_wr_data}, 0);
        end else begin
          logic [11:0] e;
          e = exp_rf.pop_front();
          check(cur_req, {rf_wr_addr, rf_wr_data} == e, "register write {reg,data}",
                {rf_wr_addr, rf_wr_data}, e);
        end
      end
    end
  end

  // driver: issue one instruction, wait for done, count accepting edges
  task automatic run_op(input logic [15:0] ins, input bit junk, output int edges,
                        output bit warn_seen);
    @(negedge clk);
    start = 1'b1;
    instr = ins;
    @(posedge clk);
    edges = 1;
    @(negedge clk);
    if (junk) instr = 16'hA123;
    else      start = 1'b0;
    while (!done && edges < 200) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (edges >= 4) start = 1'b0;
    end
    warn_seen = glyph_warn;
    @(negedge clk);
    check("R11", !done && !busy, "done/busy after done pulse", {done, busy}, 0);
    check(cur_req, exp_mem.size() == 0 && exp_rf.size() == 0,
          "scoreboard drained", exp_mem.size() + exp_rf.size(), 0);
    check(cur_req, index_o == exp_idx, "index", index_o, exp_idx);
  endtask

  task automatic set_index(input logic [11:0] v);
    int e; bit w;
    cur_req = "R2";
    exp_idx = v;
    run_op({4'hA, v}, 1'b0, e, w);
    check("R2", e == 1, "edges to done", e, 1);
  endtask

  task automatic do_digits(input logic [3:0] x, input bit junk);
    int e; bit w;
    int v;
    cur_req = "R3";
    v = rf[x];
    exp_mem.push_back({exp_idx,          8'(v / 100)});
    exp_mem.push_back({exp_idx + 12'd1,  8'((v / 10) % 10)});
    exp_mem.push_back({exp_idx + 12'd2,  8'(v % 10)});
    run_op({4'hF, x, 8'h33}, junk, e, w);
    check(junk ? "R10" : "R4", e == 12, "digit op edges to done", e, 12);
  endtask

  task automatic do_store(input logic [3:0] x, input string req);
    int e; bit w;
    cur_req = req;
    for (int k = 0; k <= int'(x); k++)
      exp_mem.push_back({exp_idx + 12'(k), rf[k]});
    exp_idx = exp_idx + 12'(x) + 12'd1;
    run_op({4'hF, x, 8'h55}, 1'b0, e, w);
    check(req, e == int'(x) + 2, "store edges to done", e, int'(x) + 2);
  endtask

  task automatic do_load(input logic [3:0] x);
    int e; bit w;
    cur_req = "R6";
    for (int k = 0; k <= int'(x); k++)
      exp_rf.push_back({4'(k), mem[exp_idx + 12'(k)]});
    exp_idx = exp_idx + 12'(x) + 12'd1;
    run_op({4'hF, x, 8'h65}, 1'b0, e, w);
    check("R6", e == int'(x) + 3, "load edges to done", e, int'(x) + 3);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int e; bit w;
    for (int a = 0; a < 4096; a++) mem[a] = 8'(a * 3 + 1);
    for (int r = 0; r < 16; r++)   rf[r] = 8'(8'h10 + r * 7);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", index_o == 12'h000, "index after reset", index_o, 0);
    check("R1", !busy && !done, "busy/done after reset", {busy, done}, 0);
    check("R1", !mem_en && !rf_we, "strobes in reset", {mem_en, rf_we}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", !mem_en && !rf_we && !busy, "idle after reset", {mem_en, rf_we, busy}, 0);

    set_index(12'h3F0);                        // R2

    rf[5] = 8'd234; do_digits(4'd5, 1'b0);     // R3 R4
    rf[6] = 8'd0;   do_digits(4'd6, 1'b0);
    rf[7] = 8'd255; do_digits(4'd7, 1'b0);
    rf[8] = 8'd9;   do_digits(4'd8, 1'b0);

    do_store(4'd3, "R5");                      // R5: 3F0..3F3, index 3F4
    do_store(4'd0, "R5");                      // single byte

    set_index(12'h200);
    do_load(4'd2);                             // R6
    check("R6", rf[1] == mem[12'h201], "V1 after load", rf[1], mem[12'h201]);
    set_index(12'h300);
    do_load(4'd15);
    check("R6", rf[15] == mem[12'h30F], "V15 after load", rf[15], mem[12'h30F]);

    // R7: glyph pointer
    cur_req = "R7";
    rf[9] = 8'h0B;
    exp_idx = 12'h050 + 12'd55;
    run_op(16'hF929, 1'b0, e, w);
    check("R7", w == 1'b0, "warn for 0x0B", w, 0);
    rf[10] = 8'h1B;
    run_op(16'hFA29, 1'b0, e, w);
    check("R7", w == 1'b1, "warn for 0x1B", w, 1);

    // R8: add register to index, wrapping
    set_index(12'hFF0);
    cur_req = "R8";
    rf[4] = 8'h20;
    exp_idx = 12'h010;
    run_op(16'hF41E, 1'b0, e, w);
    check("R8", e == 1, "add edges to done", e, 1);

    // R9: unsupported words
    cur_req = "R9";
    run_op(16'hF5AA, 1'b0, e, w);
    check("R9", e == 1, "edges to done", e, 1);
    run_op(16'h5120, 1'b0, e, w);
    check("R9", e == 1, "edges to done", e, 1);

    // R10: start held high with an index load during a digit op
    set_index(12'h100);
    rf[5] = 8'd147;
    do_digits(4'd5, 1'b1);

    // R12: store wraps past the top of memory
    set_index(12'hFFE);
    do_store(4'd3, "R12");
    check("R12", mem[12'h001] == rf[3], "byte at 0x001", mem[12'h001], rf[3]);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule